// File: doc/BRIEF.md
# Software Standby Wake Controller

This block sequences a small microcontroller into and out of a deep, oscillator-off standby state. The CPU raises a sleep request. If the standby-enable control bit is set at that moment, the block turns off the oscillator enable and both clock-gate enables. It holds the serial-interface and converter modules in reset. It also applies a bus pin policy chosen by a hold bit, which is captured at entry.

While in standby the block watches six wake sources: the hardware-standby pin, the reset pin, the non-maskable interrupt, and three qualified external interrupt lines. These inputs are synchronised by two flops on the always-running reference clock. Each source has its own exit path. An interrupt wake restarts the oscillator and counts out a programmable stabilisation time. It then restores the clocks and sends a one-cycle interrupt-exception request, together with a code naming the source. A reset-pin wake restores every clock at once and holds CPU reset until the pin rises, then sends a reset-exception start. The hardware-standby pin overrides everything and parks the block in a separate state that only a power-on reset can leave.

Top module: `stby_wake_ctrl`

## Requirements
- R1: Standby is entered on the clock edge where `sleep_req_i` and `stby_en_i` are both 1. A sleep request with `stby_en_i` at 0 leaves the block running with clocks on.
- R2: While `in_stby_o` is 1, `osc_en_o`, `cpu_clk_en_o` and `per_clk_en_o` are all 0.
- R3: `sci_rst_o` and `adc_rst_o` are 1 from standby entry until clocks resume, and 0 in normal running.
- R4: The value of `hold_bus_i` is captured on entry. During standby, `bus_hiz_o` is 1 when that captured value is 0, and 0 when it is 1.
- R5: IRQ line i can wake the block only when `irq_en_i[i]` is 1, `irq_mask_i[i]` is 0 and `irq_xfer_i[i]` is 0. Otherwise the line is ignored and the block stays in standby.
- R6: After an NMI or IRQ wake, `osc_en_o` is 1 with clocks off for exactly 2^(STAB_BASE_LOG2+min(sel,5)) cycles, where sel is `stab_sel_i`. Clocks then turn on, and `irq_exc_o` is 1 for exactly their first cycle.
- R7: A low `res_ni` in standby turns the oscillator and all clocks on together and asserts `cpu_rst_o` while the pin stays low. On release, `cpu_rst_o` falls and `rst_exc_o` pulses for one cycle.
- R8: A low `stby_pin_ni` in standby or during stabilisation enters hardware standby. There `hw_stby_o` is 1, the oscillator and clocks are off and `bus_hiz_o` is 1. The state persists until `rst_ni`.
- R9: When several wake sources are active at once, the winner is chosen in this order: hardware-standby pin, reset pin, NMI, IRQ0, IRQ1, IRQ2. `wake_code_o` reports the winner as 6, 5, 1, 2, 3, 4 respectively.
- R10: After `rst_ni` the block runs with the oscillator and clocks on, and with no exception, reset or standby outputs asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req_i | input | 1 | Sleep request from CPU |
| stby_en_i | input | 1 | Standby-enable control bit |
| hold_bus_i | input | 1 | 1: bus pins hold in standby, 0: high-impedance |
| stab_sel_i | input | 3 | Stabilisation time select |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_i | input | N_IRQ | External interrupt lines |
| irq_en_i | input | N_IRQ | Per-line enable |
| irq_mask_i | input | N_IRQ | Per-line CPU-side mask |
| irq_xfer_i | input | N_IRQ | Line assigned as transfer trigger |
| res_ni | input | 1 | Reset pin, active low |
| stby_pin_ni | input | 1 | Hardware-standby pin, active low |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| sci_rst_o | output | 1 | Serial interface module reset |
| adc_rst_o | output | 1 | Converter module reset |
| bus_hiz_o | output | 1 | Address/bus control pins to high-impedance |
| cpu_rst_o | output | 1 | Reset held to CPU |
| rst_exc_o | output | 1 | Reset-exception start pulse |
| irq_exc_o | output | 1 | Interrupt-exception request pulse |
| wake_code_o | output | 3 | Last wake source code |
| hw_stby_o | output | 1 | Hardware standby state |
| in_stby_o | output | 1 | Software standby state |

## Verification
The bench builds the block with STAB_BASE_LOG2 = 2 and three IRQ lines. This turns the stabilisation windows into 4 to 128 cycles, so all eight select codes, including the two that saturate, are timed cycle by cycle in one run. With windows that short, the bench can sweep all eight enable/mask/transfer combinations on each IRQ line and all fifteen simultaneous NMI/IRQ patterns. It can also interrupt a long window with the hardware-standby pin.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_STBY, ST_STAB, ST_RSTH, ST_HWS
  } pmode_e;

  localparam logic [2:0] WK_NONE = 3'd0;
  localparam logic [2:0] WK_NMI  = 3'd1;
  localparam logic [2:0] WK_IRQ0 = 3'd2;
  localparam logic [2:0] WK_RES  = 3'd5;
  localparam logic [2:0] WK_HWS  = 3'd6;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/stby_wake_arb.sv
module stby_wake_arb #(
  parameter int N_IRQ = 3
) (
  input  logic             hw_i,
  input  logic             res_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             req_o,
  output logic [2:0]       code_o
);
  import stby_pkg::*;

  always_comb begin
    req_o  = hw_i | res_i | nmi_i | (|irq_i);
    code_o = WK_NONE;
    // lowest index wins among IRQs
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irq_i[i]) code_o = WK_IRQ0 + 3'(i);
    end
    if (nmi_i) code_o = WK_NMI;
    if (res_i) code_o = WK_RES;
    if (hw_i)  code_o = WK_HWS;
  end
endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_STEP  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] sel_i,
  output logic       done_o
);
  localparam int CW = BASE_LOG2 + MAX_STEP + 1;

  logic [CW-1:0] cnt_q;
  logic [2:0]    step;
  logic [CW-1:0] load_val;

  always_comb begin
    step     = (int'(sel_i) > MAX_STEP) ? 3'(MAX_STEP) : sel_i;
    load_val = (CW'(1) << (BASE_LOG2 + int'(step))) - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl #(
  parameter int N_IRQ          = 3,
  parameter int STAB_BASE_LOG2 = 13,
  parameter int STAB_MAX_STEP  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             stby_en_i,
  input  logic             hold_bus_i,
  input  logic [2:0]       stab_sel_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_mask_i,
  input  logic [N_IRQ-1:0] irq_xfer_i,
  input  logic             res_ni,
  input  logic             stby_pin_ni,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             sci_rst_o,
  output logic             adc_rst_o,
  output logic             bus_hiz_o,
  output logic             cpu_rst_o,
  output logic             rst_exc_o,
  output logic             irq_exc_o,
  output logic [2:0]       wake_code_o,
  output logic             hw_stby_o,
  output logic             in_stby_o
);
  import stby_pkg::*;

  localparam int SW = N_IRQ + 3;

  pmode_e state_q, state_d;
  logic [2:0] code_q, code_d;
  logic hold_q, hold_d;
  logic irq_exc_q, irq_exc_d, rst_exc_q, rst_exc_d;

  logic [SW-1:0] raw_w, sync_w;
  logic nmi_s, res_s_n, hws_s_n;
  logic [N_IRQ-1:0] irq_s, irq_ok;

  assign raw_w = {stby_pin_ni, res_ni, nmi_i, irq_i};

  stby_sync #(
    .W      (SW),
    .RST_VAL({2'b11, {(N_IRQ + 1){1'b0}}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_w),
    .q_o   (sync_w)
  );

  assign {hws_s_n, res_s_n, nmi_s, irq_s} = sync_w;
  assign irq_ok = irq_s & irq_en_i & ~irq_mask_i & ~irq_xfer_i;

  logic wk_req;
  logic [2:0] wk_code;

  stby_wake_arb #(.N_IRQ(N_IRQ)) u_arb (
    .hw_i  (~hws_s_n),
    .res_i (~res_s_n),
    .nmi_i (nmi_s),
    .irq_i (irq_ok),
    .req_o (wk_req),
    .code_o(wk_code)
  );

  logic tmr_load, tmr_done;

  stby_stab_timer #(
    .BASE_LOG2(STAB_BASE_LOG2),
    .MAX_STEP (STAB_MAX_STEP)
  ) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .sel_i (stab_sel_i),
    .done_o(tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    code_d    = code_q;
    hold_d    = hold_q;
    irq_exc_d = 1'b0;
    rst_exc_d = 1'b0;
    tmr_load  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req_i && stby_en_i) begin
          state_d = ST_STBY;
          hold_d  = hold_bus_i;
        end
      end
      ST_STBY: begin
        if (wk_req) begin
          code_d = wk_code;
          if (wk_code == WK_HWS)      state_d = ST_HWS;
          else if (wk_code == WK_RES) state_d = ST_RSTH;
          else begin
            state_d  = ST_STAB;
            tmr_load = 1'b1;
          end
        end
      end
      ST_STAB: begin
        if (!hws_s_n) begin
          state_d = ST_HWS;
          code_d  = WK_HWS;
        end else if (!res_s_n) begin
          state_d = ST_RSTH;
          code_d  = WK_RES;
        end else if (tmr_done) begin
          state_d   = ST_RUN;
          irq_exc_d = 1'b1;
        end
      end
      ST_RSTH: begin
        if (!hws_s_n) begin
          state_d = ST_HWS;
          code_d  = WK_HWS;
        end else if (res_s_n) begin
          state_d   = ST_RUN;
          rst_exc_d = 1'b1;
        end
      end
      ST_HWS:  state_d = ST_HWS;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RUN;
      code_q    <= WK_NONE;
      hold_q    <= 1'b0;
      irq_exc_q <= 1'b0;
      rst_exc_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      code_q    <= code_d;
      hold_q    <= hold_d;
      irq_exc_q <= irq_exc_d;
      rst_exc_q <= rst_exc_d;
    end
  end

  logic asleep;
  assign asleep = (state_q == ST_STBY) || (state_q == ST_STAB);

  assign osc_en_o     = (state_q == ST_RUN) || (state_q == ST_STAB) || (state_q == ST_RSTH);
  assign cpu_clk_en_o = (state_q == ST_RUN) || (state_q == ST_RSTH);
  assign per_clk_en_o = cpu_clk_en_o;
  assign sci_rst_o    = asleep || (state_q == ST_HWS);
  assign adc_rst_o    = sci_rst_o;
  assign bus_hiz_o    = (state_q == ST_HWS) || (asleep && !hold_q);
  assign cpu_rst_o    = (state_q == ST_RSTH);
  assign rst_exc_o    = rst_exc_q;
  assign irq_exc_o    = irq_exc_q;
  assign wake_code_o  = code_q;
  assign hw_stby_o    = (state_q == ST_HWS);
  assign in_stby_o    = (state_q == ST_STBY);
endmodule

// File: rtl/stby_wake_ctrl_chk.sv
module stby_wake_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic       stby_en_i,
  input logic       osc_en_o,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       sci_rst_o,
  input logic       adc_rst_o,
  input logic       cpu_rst_o,
  input logic       irq_exc_o,
  input logic [2:0] wake_code_o,
  input logic       hw_stby_o,
  input logic       in_stby_o
);
  a_r1_entry_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_stby_o) |-> $past(sleep_req_i && stby_en_i));

  a_r2_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stby_o |-> (!osc_en_o && !cpu_clk_en_o && !per_clk_en_o));

  a_r3_module_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stby_o |-> (sci_rst_o && adc_rst_o));

  a_r6_exc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_o |=> !irq_exc_o);

  a_r6_exc_with_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_exc_o |-> (cpu_clk_en_o && osc_en_o));

  a_r7_reset_clocks_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_o |-> (osc_en_o && cpu_clk_en_o && per_clk_en_o));

  a_r8_hw_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_o |=> hw_stby_o);

  a_r9_hw_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_o |-> (wake_code_o == 3'd6));
endmodule

bind stby_wake_ctrl stby_wake_ctrl_chk u_chk (.*);

// File: tb/stby_wake_ctrl_test.sv
module stby_wake_ctrl_test;
  localparam int NI = 3;
  localparam int BL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep_req = 0, stby_en = 0, hold_bus = 0, nmi = 0;
  logic [2:0] stab_sel = 0;
  logic [NI-1:0] irq = 0, irq_en = 0, irq_mask = 0, irq_xfer = 0;
  logic res_n = 1, stby_n = 1;
  logic osc_en, cpu_clk_en, per_clk_en, sci_rst, adc_rst, bus_hiz;
  logic cpu_rst, rst_exc, irq_exc, hw_stby, in_stby;
  logic [2:0] wake_code;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  stby_wake_ctrl #(.N_IRQ(NI), .STAB_BASE_LOG2(BL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .stby_en_i(stby_en),
    .hold_bus_i(hold_bus), .stab_sel_i(stab_sel), .nmi_i(nmi), .irq_i(irq),
    .irq_en_i(irq_en), .irq_mask_i(irq_mask), .irq_xfer_i(irq_xfer),
    .res_ni(res_n), .stby_pin_ni(stby_n), .osc_en_o(osc_en),
    .cpu_clk_en_o(cpu_clk_en), .per_clk_en_o(per_clk_en), .sci_rst_o(sci_rst),
    .adc_rst_o(adc_rst), .bus_hiz_o(bus_hiz), .cpu_rst_o(cpu_rst),
    .rst_exc_o(rst_exc), .irq_exc_o(irq_exc), .wake_code_o(wake_code),
    .hw_stby_o(hw_stby), .in_stby_o(in_stby)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic do_reset;
    rst_n = 0; nmi = 0; irq = 0; res_n = 1; stby_n = 1; sleep_req = 0;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic enter_stby(bit hold);
    sleep_req = 1; stby_en = 1; hold_bus = hold;
    tick(1);
    sleep_req = 0;
    chk(in_stby == 1, "R1 enter", int'(in_stby), 1);
  endtask

  // waits until CPU clock returns; counts cycles with oscillator on
  task automatic wait_clk(output int osc_cyc);
    int k = 0;
    osc_cyc = 0;
    while (!cpu_clk_en && k < 2000) begin
      if (osc_en) osc_cyc++;
      tick(1);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int oc, exp_n, exp_code;
    bit ok;
    do_reset();
    // R10 reset state
    chk(osc_en && cpu_clk_en && per_clk_en, "R10 clocks", int'(cpu_clk_en), 1);
    chk(!in_stby && !hw_stby && !cpu_rst && !irq_exc && !rst_exc && !sci_rst,
        "R10 idle outputs", int'(in_stby), 0);

    // R1: no entry without the enable bit
    stby_en = 0; sleep_req = 1; tick(1); sleep_req = 0; tick(1);
    chk(!in_stby && cpu_clk_en, "R1 sleep without enable", int'(in_stby), 0);
    stby_en = 1; tick(3);
    chk(!in_stby, "R1 enable without sleep", int'(in_stby), 0);

    // R6 stabilisation sweep over all select codes, R2 R3 R4 in standby
    for (int n = 0; n < 8; n++) begin
      stab_sel = 3'(n);
      enter_stby(n[0]);
      chk(!osc_en && !cpu_clk_en && !per_clk_en, "R2 clocks off", int'(osc_en), 0);
      chk(sci_rst && adc_rst, "R3 module reset", int'(sci_rst), 1);
      chk(bus_hiz == !n[0], "R4 bus policy", int'(bus_hiz), int'(!n[0]));
      hold_bus = ~hold_bus;
      nmi = 1;
      tick(3);
      chk(bus_hiz == !n[0], "R4 captured policy", int'(bus_hiz), int'(!n[0]));
      wait_clk(oc);
      exp_n = 1 << (BL + ((n > 5) ? 5 : n));
      chk(oc == exp_n, "R6 stab length", oc, exp_n);
      chk(irq_exc == 1, "R6 exception pulse", int'(irq_exc), 1);
      chk(wake_code == 3'd1, "R9 NMI code", int'(wake_code), 1);
      chk(!sci_rst && !adc_rst, "R3 reset released", int'(sci_rst), 0);
      tick(1);
      chk(irq_exc == 0, "R6 pulse one cycle", int'(irq_exc), 0);
      nmi = 0;
      tick(4);
    end

    // R5 qualification sweep
    stab_sel = 0;
    for (int i = 0; i < NI; i++) begin
      for (int c = 0; c < 8; c++) begin
        irq_en = '0; irq_mask = '0; irq_xfer = '0;
        irq_en[i] = c[0]; irq_mask[i] = c[1]; irq_xfer[i] = c[2];
        ok = c[0] && !c[1] && !c[2];
        enter_stby(0);
        irq[i] = 1;
        tick(12);
        if (ok) begin
          chk(cpu_clk_en && !in_stby, "R5 qualified wake", int'(cpu_clk_en), 1);
          chk(wake_code == 3'(2 + i), "R9 IRQ code", int'(wake_code), 2 + i);
          irq[i] = 0;
        end else begin
          chk(in_stby && !cpu_clk_en && !osc_en, "R5 ignored line", int'(in_stby), 1);
          irq[i] = 0;
          nmi = 1;
          wait_clk(oc);
          nmi = 0;
        end
        tick(4);
      end
    end

    // R9 priority among NMI and IRQs
    irq_en = '1; irq_mask = '0; irq_xfer = '0;
    for (int p = 1; p < 16; p++) begin
      enter_stby(0);
      nmi = p[0]; irq = 3'(p >> 1);
      wait_clk(oc);
      exp_code = p[0] ? 1 : p[1] ? 2 : p[2] ? 3 : 4;
      chk(wake_code == 3'(exp_code), "R9 priority", int'(wake_code), exp_code);
      chk(irq_exc == 1, "R6 exception on IRQ wake", int'(irq_exc), 1);
      nmi = 0; irq = 0;
      tick(4);
    end

    // R9 reset pin beats NMI
    enter_stby(0);
    nmi = 1; res_n = 0;
    tick(5);
    chk(cpu_rst && wake_code == 3'd5, "R9 reset over NMI", int'(wake_code), 5);
    nmi = 0; res_n = 1;
    tick(6);

    // R7 reset pin wake
    enter_stby(1);
    res_n = 0;
    begin
      int k = 0;
      while (!cpu_rst && k < 20) begin tick(1); k++; end
    end
    chk(cpu_rst == 1, "R7 reset held", int'(cpu_rst), 1);
    chk(osc_en && cpu_clk_en && per_clk_en, "R7 clocks at once", int'(cpu_clk_en), 1);
    chk(irq_exc == 0, "R7 no interrupt exception", int'(irq_exc), 0);
    tick(10);
    chk(cpu_rst == 1, "R7 reset while pin low", int'(cpu_rst), 1);
    res_n = 1;
    begin
      int k = 0;
      while (cpu_rst && k < 20) begin tick(1); k++; end
    end
    chk(rst_exc == 1, "R7 reset exception start", int'(rst_exc), 1);
    tick(1);
    chk(rst_exc == 0 && cpu_clk_en, "R7 pulse one cycle", int'(rst_exc), 0);
    tick(4);

    // R8 standby pin during stabilisation, also beats reset pin
    stab_sel = 7;
    enter_stby(1);
    nmi = 1;
    begin
      int k = 0;
      while (!osc_en && k < 20) begin tick(1); k++; end
    end
    tick(2);
    stby_n = 0; res_n = 0;
    begin
      int k = 0;
      while (!hw_stby && k < 20) begin tick(1); k++; end
    end
    chk(hw_stby == 1, "R8 hardware standby", int'(hw_stby), 1);
    chk(!osc_en && !cpu_clk_en && bus_hiz, "R8 outputs off", int'(osc_en), 0);
    chk(wake_code == 3'd6, "R9 standby pin code", int'(wake_code), 6);
    nmi = 0; stby_n = 1; res_n = 1;
    tick(20);
    chk(hw_stby && !cpu_clk_en, "R8 state persists", int'(hw_stby), 1);
    do_reset();
    chk(!hw_stby && cpu_clk_en, "R10 reset leaves hw standby", int'(hw_stby), 0);

    // R9 all sources at once from standby
    stab_sel = 0;
    enter_stby(0);
    nmi = 1; irq = '1; res_n = 0; stby_n = 0;
    tick(5);
    chk(hw_stby && wake_code == 3'd6, "R9 standby pin highest", int'(wake_code), 6);
    do_reset();

    summary();
    $finish;
  end
endmodule